// File: doc/BRIEF.md
# Handshaked 32-bit Parallel Word Input Port

This block lets the processor side fetch one 32-bit word from a set of static input lines fed by an outside device. A single-cycle request carries an 8-bit command code. The block then drives that code on eight command lines, together with a read strobe, for a fixed number of cycles. After the strobe has ended, the block watches a hold line from the device. The device raises hold while its data lines are changing, and can hold off the capture for as long as it needs.

The word is captured only after hold has stayed low, through a two-flop synchroniser, for a minimum number of consecutive cycles. The input lines carry no parity, so the block produces one odd-parity bit per byte of the captured word. It returns the word with a one-cycle valid pulse. A source that never changes can tie hold low, and each read then finishes a fixed number of cycles after the request. If hold stays high for too long, an optional counter raises a sticky flag, but the wait still continues.

Top module: `word_in_port`

## Requirements
- R1: After reset, cmd_out, rd_strobe, data_out, parity_out, data_valid, busy and hold_timeout are all zero.
- R2: An accepted request drives rd_strobe high for exactly STROBE_CYC cycles, starting the cycle after the accepting edge. During those cycles cmd_out equals the request's command code; outside them cmd_out is zero.
- R3: Hold is not examined during the strobe. With hold low and settled, data_valid rises exactly STROBE_CYC+LOW_CYC cycles after the accepting edge.
- R4: While the synchronised hold is high, the read does not complete. After hold falls, data_valid appears LOW_CYC+2 clock edges later (two synchroniser stages plus LOW_CYC low cycles). If hold rises again before then, the low count restarts.
- R5: On data_valid, data_out holds the word on data_in at the capture edge. Each parity_out[i] makes the byte data_out[31-8i:24-8i] together with that bit contain an odd number of ones, so parity_out[0] covers bits 31..24.
- R6: busy is high from the cycle after the accepting edge through the cycle before data_valid, and is low in the data_valid cycle. A request made while busy is ignored: cmd_out does not change and no second read follows.
- R7: data_valid lasts one cycle. data_out and parity_out keep their values until the next capture, even if data_in changes.
- R8: With TIMEOUT_EN set, hold_timeout rises after hold has been high for TIMEOUT_CYC consecutive waiting cycles. The read still completes once hold falls, and the flag stays set until the next request is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle read request |
| req_cmd | input | 8 | Command code for this read |
| cmd_out | output | 8 | Command lines, pulsed with the strobe |
| rd_strobe | output | 1 | Read strobe pulse |
| hold_in | input | 1 | Device hold, high while its data lines change |
| data_in | input | 32 | Static input word lines |
| data_out | output | 32 | Captured word |
| parity_out | output | 4 | Odd parity per byte, bit 0 for bits 31..24 |
| data_valid | output | 1 | One-cycle pulse when a word is captured |
| busy | output | 1 | A read is in progress |
| hold_timeout | output | 1 | Sticky flag: hold was high too long |

## Verification
The bench builds the block with STROBE_CYC=3, LOW_CYC=4, TIMEOUT_CYC=10 and the timeout enabled. These small values keep every exact latency (strobe plus low count, and release plus synchroniser plus low count) within a few cycles, so each one can be checked edge by edge. They also let a hold held high for twenty cycles reach the timeout, while a short hold stays below it. With these sizes, many random reads and the restart-on-reassert case all fit in a short run.

// File: rtl/word_in_port.sv
module word_in_port #(
  parameter int STROBE_CYC  = 25,
  parameter int LOW_CYC     = 25,
  parameter int TIMEOUT_CYC = 5000,
  parameter bit TIMEOUT_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [7:0]  req_cmd,
  output logic [7:0]  cmd_out,
  output logic        rd_strobe,
  input  logic        hold_in,
  input  logic [31:0] data_in,
  output logic [31:0] data_out,
  output logic [3:0]  parity_out,
  output logic        data_valid,
  output logic        busy,
  output logic        hold_timeout
);
  localparam int MAXC = (STROBE_CYC > LOW_CYC) ? STROBE_CYC : LOW_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_WAIT} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [7:0]    cmd_q;
  logic [1:0]    hsync;
  logic          hold_s;
  logic          accept;

  assign hold_s    = hsync[1];
  assign accept    = (st == S_IDLE) && req;
  assign rd_strobe = (st == S_STROBE);
  assign cmd_out   = rd_strobe ? cmd_q : 8'h00;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      cmd_q      <= '0;
      hsync      <= '0;
      data_out   <= '0;
      parity_out <= '0;
      data_valid <= 1'b0;
    end else begin
      hsync      <= {hsync[0], hold_in};
      data_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          cmd_q <= req_cmd;
          cnt   <= '0;
          st    <= S_STROBE;
        end
        S_STROBE: if (cnt == CW'(STROBE_CYC - 1)) begin
          cnt <= '0;
          st  <= S_WAIT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_WAIT: if (hold_s) begin
          cnt <= '0;
        end else if (cnt == CW'(LOW_CYC - 1)) begin
          data_out <= data_in;
          for (int i = 0; i < 4; i++) parity_out[i] <= ~^data_in[31-8*i -: 8];
          data_valid <= 1'b1;
          cnt <= '0;
          st  <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (TIMEOUT_EN) begin : g_tmo
      localparam int TW = $clog2(TIMEOUT_CYC + 1);
      logic [TW-1:0] tcnt;
      logic          waiting_hi;
      logic          flag;
      assign waiting_hi   = (st == S_WAIT) && hold_s;
      assign hold_timeout = flag;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tcnt <= '0;
          flag <= 1'b0;
        end else begin
          if (accept) flag <= 1'b0;
          else if (waiting_hi && tcnt == TW'(TIMEOUT_CYC - 1)) flag <= 1'b1;
          if (!waiting_hi) tcnt <= '0;
          else if (tcnt != TW'(TIMEOUT_CYC)) tcnt <= tcnt + 1'b1;
        end
      end
      assert_flag_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> busy);
    end else begin : g_no_tmo
      assign hold_timeout = 1'b0;
    end
  endgenerate

  assert_cmd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |-> cmd_out == 8'h00);
  assert_cmd_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && $past(rd_strobe) |-> $stable(cmd_out));
  assert_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> busy);
  assert_valid_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !busy && $past(busy));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  assert_data_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> $stable(data_out) && $stable(parity_out));
  assert_parity_odd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $countones({data_out[31:24], parity_out[0]}) % 2 == 1 &&
                   $countones({data_out[7:0], parity_out[3]}) % 2 == 1);
  assert_no_valid_under_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_strobe && hold_s |=> !data_valid);
endmodule

// File: tb/sim_word_in_port.sv
module sim_word_in_port;
  localparam int SC = 3, LC = 4, TC = 10;
  logic clk = 0, rst_n = 0, req = 0, hold_in = 0;
  logic [7:0] req_cmd = 0, cmd_out;
  logic [31:0] data_in = 0, data_out;
  logic [3:0] parity_out;
  logic rd_strobe, data_valid, busy, hold_timeout;
  int checks = 0, fails = 0, cyc = 0;

  word_in_port #(.STROBE_CYC(SC), .LOW_CYC(LC), .TIMEOUT_CYC(TC), .TIMEOUT_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .cmd_out(cmd_out),
    .rd_strobe(rd_strobe), .hold_in(hold_in), .data_in(data_in), .data_out(data_out),
    .parity_out(parity_out), .data_valid(data_valid), .busy(busy), .hold_timeout(hold_timeout));

  always #10 clk = ~clk;

  function automatic logic [3:0] exp_par(input logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ($countones(d[31-8*i -: 8]) % 2) == 0;
    return p;
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  // issue request; returns after the negedge following the accepting edge
  task automatic issue(input logic [7:0] c);
    @(negedge clk); req = 1; req_cmd = c;
    @(negedge clk); req = 0; req_cmd = 8'h00;
  endtask

  // count negedges (starting from current = n0) until data_valid
  task automatic wait_valid(input int n0, output int n);
    n = n0;
    while (!data_valid && n < 200) begin
      chk("R6 busy while waiting", busy, 1);
      @(negedge clk); n++;
    end
  endtask

  task automatic read_low(input logic [7:0] c, input logic [31:0] d);
    int n, shigh;
    data_in = d;
    issue(c);
    shigh = 0;
    while (rd_strobe) begin
      chk("R2 cmd during strobe", cmd_out, c);
      shigh++; @(negedge clk);
    end
    chk("R2 strobe width", shigh, SC);
    chk("R2 cmd quiet after strobe", cmd_out, 0);
    wait_valid(shigh + 1, n);
    chk("R3 latency hold low", n, SC + LC + 1);
    chk("R6 busy low at valid", busy, 0);
    chk("R5 data", data_out, d);
    chk("R5 parity", parity_out, exp_par(d));
  endtask

  initial begin
    int n;
    logic [31:0] d;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk("R1 cmd_out", cmd_out, 0); chk("R1 strobe", rd_strobe, 0);
    chk("R1 data", {data_out, parity_out}, 0); chk("R1 valid busy tmo", {data_valid, busy, hold_timeout}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset release", {busy, data_valid, rd_strobe}, 0);

    read_low(8'hA5, 32'h0000_0000);
    read_low(8'hFF, 32'hFFFF_FFFF);
    read_low(8'h01, 32'h8001_7F00);
    for (int k = 0; k < 30; k++) read_low(8'($urandom), $urandom);

    // R7 data held
    d = data_out; data_in = ~d;
    @(negedge clk);
    chk("R7 valid one cycle", data_valid, 0);
    repeat (5) @(negedge clk);
    chk("R7 data held", data_out, d);
    chk("R7 parity held", parity_out, exp_par(d));

    // R6 ignored request while busy
    data_in = 32'h1357_9BDF;
    issue(8'h3C);
    @(negedge clk); req = 1; req_cmd = 8'hC3;
    @(negedge clk); req = 0;
    chk("R6 cmd unchanged by busy req", cmd_out, 8'h3C);
    wait_valid(3, n);
    chk("R6 first read completes", data_out, 32'h1357_9BDF);
    repeat (12) begin
      @(negedge clk);
      chk("R6 no second read", {rd_strobe, busy, data_valid}, 0);
    end

    // R4 hold stall and release latency
    hold_in = 1; data_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    issue(8'h5A);
    repeat (5) @(negedge clk);
    chk("R4 stalled", {busy, data_valid}, 2'b10);
    chk("R8 no timeout on short hold", hold_timeout, 0);
    hold_in = 0;
    wait_valid(0, n);
    chk("R4 release latency", n, LC + 2);
    chk("R5 data after hold", data_out, 32'hDEAD_BEEF);

    // R4 restart on re-assert
    hold_in = 1; data_in = 32'h0F0F_00FF;
    issue(8'h77);
    repeat (6) @(negedge clk);
    hold_in = 0;
    repeat (2) @(negedge clk);
    hold_in = 1;
    repeat (3) @(negedge clk);
    chk("R4 no capture during glitch", {busy, data_valid}, 2'b10);
    hold_in = 0;
    wait_valid(0, n);
    chk("R4 restart latency", n, LC + 2);
    chk("R5 parity after restart", parity_out, exp_par(32'h0F0F_00FF));

    // R8 timeout
    hold_in = 1; data_in = 32'h2468_ACE0;
    issue(8'h99);
    repeat (20) @(negedge clk);
    chk("R8 timeout set", hold_timeout, 1);
    chk("R8 still waiting", busy, 1);
    hold_in = 0;
    wait_valid(0, n);
    chk("R8 completes after timeout", data_out, 32'h2468_ACE0);
    chk("R8 flag sticky", hold_timeout, 1);
    issue(8'h11);
    chk("R8 cleared by new request", hold_timeout, 0);
    wait_valid(1, n);
    chk("R3 latency after timeout", n, SC + LC + 1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule